// File: doc/BRIEF.md
# Reference-Locked Clock Multiplier

This block makes a slow square-wave clock whose frequency is a fixed integer multiple of an even slower reference. A typical reference is a mains-derived square wave at 50 or 60 Hz, with the output fourteen times faster. The only timebase used is a fast system clock. The reference is brought into the system-clock domain through a synchronizer chain. Each of its rising edges restarts the output phase, so that a rising output edge lines up with the reference.

The output half-period is a count of system-clock cycles held in a divider register. The divider's starting value comes from the parameters: system frequency divided by (multiplier times reference frequency), divided by two. At every reference rising edge the block compares the number of output toggles made during the period just ended with twice the multiplier. It then moves the divider by one step toward the value that would have matched.

The block carries no data stream, so it has no valid/ready handshake. The reference input and the clock output are plain level signals. The current divider value is brought out for observation.

Top module: `ref_lock_mult`

## Requirements
- R1: While `rst_n` is low, `clk_out` is 0 and `half_period` equals SYS_HZ/(MULT*REF_HZ)/2, clamped to the range 1 to 2^DIV_W-1.
- R2: A reference rise is first seen high at a system clock edge k. At edge k+2 the block sets `clk_out` to 1 and restarts its half-period count. Each rise produces exactly one such restart.
- R3: Between reference rises, `clk_out` toggles every `half_period` system-clock cycles, counted from the last restart or toggle.
- R4: At a reference rise, if more than 2*MULT toggles occurred since the previous rise, `half_period` increases by 1.
- R5: At a reference rise, if fewer than 2*MULT toggles occurred since the previous rise, `half_period` decreases by 1.
- R6: At a reference rise, if exactly 2*MULT toggles occurred since the previous rise, `half_period` is unchanged.
- R7: `half_period` never goes below 1 and never goes above 2^DIV_W-1. A step that would cross a bound leaves it at that bound.
- R8: The first reference rise after reset only restarts the phase. It leaves `half_period` unchanged.
- R9: When a restart falls in the same cycle as a half-period expiry, the restart wins. `clk_out` becomes 1, and that expiry is not counted as a toggle.
- R10: The toggle count saturates at 2^TOG_W-1 and does not wrap, so a very long reference period still counts as too many toggles.
- R11: A falling reference edge, or a reference held at either level, never changes `half_period`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Asynchronous slow reference square wave |
| clk_out | output | 1 | Generated multiplied clock |
| half_period | output | DIV_W | Current half-period divider, in system-clock cycles |

## Verification
A reference restart and a divider expiry can land on the same system-clock cycle. This happens whenever the reference period is an exact multiple of the half-period. The bench provokes it by running reference periods of exactly 2*MULT*half_period cycles. The correct result has the restart win, so only 2*MULT-1 toggles are counted and the divider drops by one. A behavioural model predicts this every cycle. An explicit check also confirms the new divider value and the cycle-exact level of `clk_out`.

// File: rtl/rlm_pkg.sv
`timescale 1ns/1ps
package rlm_pkg;

  // Outcome of comparing the toggles seen against the target count.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Nominal half-period in system cycles, clamped to a legal divider value.
  function automatic longint unsigned start_half(
    input longint unsigned sys_hz,
    input longint unsigned ref_hz,
    input longint unsigned mult,
    input int unsigned     width
  );
    longint unsigned raw;
    longint unsigned top;
    raw = sys_hz / (mult * ref_hz) / 2;
    top = (width >= 63) ? 64'h7FFF_FFFF_FFFF_FFFF : ((64'd1 << width) - 64'd1);
    if (raw < 64'd1) raw = 64'd1;
    if (raw > top)   raw = top;
    return raw;
  endfunction

endpackage

// File: rtl/rlm_ref_sync.sv
`timescale 1ns/1ps
// Synchronizer chain for the reference followed by rise detection.
module rlm_ref_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_async,
  output logic rise
);

  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= ref_async;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= 1'b0;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  // Previous synchronized sample, compared against the newest one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/rlm_half_timer.sv
`timescale 1ns/1ps
// Half-period counter and output flop; a restart overrides any expiry.
module rlm_half_timer #(
  parameter int unsigned DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             align,
  input  logic [DIV_W-1:0] half,
  output logic             out_q,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             expire;

  // Greater-or-equal keeps a shrinking divider from stranding the count.
  assign expire = (cnt_q >= (half - 1'b1));
  assign tick   = expire & ~align;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (align) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (expire) begin
      cnt_q <= '0;
      out_q <= ~out_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/rlm_ratio_ctl.sv
`timescale 1ns/1ps
// Counts output toggles per reference period and steps the divider.
module rlm_ratio_ctl
  import rlm_pkg::*;
#(
  parameter int unsigned      MULT  = 14,
  parameter int unsigned      DIV_W = 32,
  parameter int unsigned      TOG_W = 16,
  parameter logic [DIV_W-1:0] INIT  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             align,
  input  logic             tick,
  output logic [DIV_W-1:0] half_q
);

  localparam logic [TOG_W-1:0] TARGET   = TOG_W'(2 * MULT);
  localparam logic [TOG_W-1:0] TOG_MAX  = '1;
  localparam logic [DIV_W-1:0] HALF_MAX = '1;
  localparam logic [DIV_W-1:0] HALF_MIN = DIV_W'(1);

  logic [TOG_W-1:0] tog_q;
  logic             armed_q;
  step_e            step;

  always_comb begin
    if (tog_q > TARGET)      step = STEP_UP;
    else if (tog_q < TARGET) step = STEP_DOWN;
    else                     step = STEP_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q   <= '0;
      armed_q <= 1'b0;
      half_q  <= INIT;
    end else if (align) begin
      tog_q   <= '0;
      armed_q <= 1'b1;
      if (armed_q) begin
        unique case (step)
          STEP_UP:   if (half_q != HALF_MAX) half_q <= half_q + 1'b1;
          STEP_DOWN: if (half_q > HALF_MIN)  half_q <= half_q - 1'b1;
          default:   half_q <= half_q;
        endcase
      end
    end else if (tick && (tog_q != TOG_MAX)) begin
      tog_q <= tog_q + 1'b1;
    end
  end

endmodule

// File: rtl/ref_lock_mult.sv
`timescale 1ns/1ps
// Reference-locked clock multiplier top level.
module ref_lock_mult #(
  parameter int unsigned MULT        = 14,
  parameter int unsigned REF_HZ      = 60,
  parameter int unsigned SYS_HZ      = 200_000_000,
  parameter int unsigned DIV_W       = 32,
  parameter int unsigned TOG_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  output logic             clk_out,
  output logic [DIV_W-1:0] half_period
);

  localparam logic [DIV_W-1:0] HALF_INIT =
    DIV_W'(rlm_pkg::start_half(SYS_HZ, REF_HZ, MULT, DIV_W));

  logic ref_rise;
  logic half_tick;

  rlm_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_async (ref_in),
    .rise      (ref_rise)
  );

  rlm_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .align (ref_rise),
    .half  (half_period),
    .out_q (clk_out),
    .tick  (half_tick)
  );

  rlm_ratio_ctl #(
    .MULT  (MULT),
    .DIV_W (DIV_W),
    .TOG_W (TOG_W),
    .INIT  (HALF_INIT)
  ) u_ratio (
    .clk    (clk),
    .rst_n  (rst_n),
    .align  (ref_rise),
    .tick   (half_tick),
    .half_q (half_period)
  );

endmodule

// File: rtl/ref_lock_mult_chk.sv
`timescale 1ns/1ps
// Property checker attached to the top level.
module ref_lock_mult_chk #(
  parameter int unsigned DIV_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_rise,
  input logic             clk_out,
  input logic [DIV_W-1:0] half_period
);

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= 1'b0;
    else if (ref_rise) seen_q <= 1'b1;
  end

  AST_EDGE_SETS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> clk_out); // R2

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> !ref_rise); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> ((half_period == $past(half_period)) ||
                  (half_period == $past(half_period) + 1'b1) ||
                  (half_period == $past(half_period) - 1'b1))); // R4

  AST_DIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    half_period != '0); // R7

  AST_FIRST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_rise && !seen_q) |=> $stable(half_period)); // R8

  AST_QUIET_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_rise |=> $stable(half_period)); // R11

endmodule

bind ref_lock_mult ref_lock_mult_chk #(.DIV_W(DIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ref_rise    (ref_rise),
  .clk_out     (clk_out),
  .half_period (half_period)
);

// File: tb/ref_lock_mult_bench.sv
`timescale 1ns/1ps
module ref_lock_mult_bench;

  localparam int MULT  = 4;
  localparam int DIV_W = 5;
  localparam int TOG_W = 6;
  localparam int INIT  = 25;            // 200000/(4*1000)/2
  localparam int DMAX  = (1 << DIV_W) - 1;
  localparam int TMAX  = (1 << TOG_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ref_in = 1'b0;
  logic             clk_out;
  logic [DIV_W-1:0] half_period;

  always #2.5 clk = ~clk;

  ref_lock_mult #(
    .MULT(MULT), .REF_HZ(1000), .SYS_HZ(200000),
    .DIV_W(DIV_W), .TOG_W(TOG_W), .SYNC_STAGES(2)
  ) u_ref_lock_mult (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
    .clk_out(clk_out), .half_period(half_period)
  );

  int    vectors = 0;
  int    errs = 0;
  int    cyc = 0;
  string tag = "R1";

  // Behavioural model state
  int m_s1 = 0, m_s2 = 0, m_prev = 0;
  int m_cnt = 0, m_div = INIT, m_tog = 0, m_armed = 0, m_out = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0;
      m_cnt = 0; m_div = INIT; m_tog = 0; m_armed = 0; m_out = 0;
    end else begin
      if (m_s2 == 1 && m_prev == 0) begin
        if (m_armed == 1) begin
          if (m_tog > 2 * MULT && m_div < DMAX) m_div++;
          else if (m_tog < 2 * MULT && m_div > 1) m_div--;
        end
        m_armed = 1; m_cnt = 0; m_tog = 0; m_out = 1;
      end else if (m_cnt >= m_div - 1) begin
        m_cnt = 0; m_out = 1 - m_out;
        if (m_tog < TMAX) m_tog++;
      end else begin
        m_cnt++;
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(ref_in);
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    vectors++;
    if (clk_out !== 1'(m_out) || half_period !== DIV_W'(m_div)) begin
      errs++;
      $display("FAIL %s cycle %0d: clk_out=%0b half=%0d expected clk_out=%0d half=%0d",
               tag, cyc, clk_out, half_period, m_out, m_div);
    end
    if (cyc > 150000) begin
      errs++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  task automatic check_half(input string req, input int exp);
    vectors++;
    if (half_period !== DIV_W'(exp)) begin
      errs++;
      $display("FAIL %s: half_period=%0d expected %0d", req, half_period, exp);
    end
  endtask

  task automatic ref_period(input int hi, input int lo);
    ref_in = 1'b1;
    repeat (hi) @(negedge clk);
    ref_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  int held;

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset values
    vectors++;
    if (clk_out !== 1'b0) begin
      errs++;
      $display("FAIL R1: clk_out=%0b expected 0", clk_out);
    end
    check_half("R1", INIT);
    rst_n = 1'b1;
    // Long idle: toggle count saturates before the first rise
    tag = "R3";
    repeat (300) @(negedge clk);
    tag = "R2";
    ref_period(105, 105);
    check_half("R8", INIT);         // first rise only aligns
    tag = "R3";
    repeat (3) ref_period(105, 105);
    check_half("R6", INIT);         // 210 cycles -> exactly 8 toggles
    tag = "R9";
    ref_period(100, 100);
    ref_period(100, 100);
    check_half("R9", INIT - 1);     // restart coincides with expiry
    tag = "R4";
    repeat (4) ref_period(200, 200);
    check_half("R4", 27);
    tag = "R7";
    repeat (8) ref_period(200, 200);
    check_half("R7", DMAX);         // upper clamp
    tag = "R5";
    repeat (5) ref_period(3, 3);
    check_half("R5", 27);
    tag = "R7";
    repeat (35) ref_period(3, 3);
    check_half("R7", 1);            // lower clamp
    tag = "R10";
    ref_period(60, 71);             // 130 toggles at half_period 1
    ref_period(3, 3);
    check_half("R10", 2);           // saturated count still reads as too many
    tag = "R11";
    ref_in = 1'b1;
    repeat (10) @(negedge clk);
    held = int'(half_period);
    repeat (290) @(negedge clk);
    check_half("R11", held);
    ref_in = 1'b0;
    repeat (100) @(negedge clk);
    check_half("R11", held);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

endmodule